// File: doc/BRIEF.md
# Block Floating Point Stage Scaler

This block keeps one shared exponent across the passes of an iterative fixed-point transform engine, such as an in-place FFT whose butterflies read and write a sample memory once per pass. The block sits on two streams. On the result stream it watches every word the butterflies write back. If any word in a pass has grown into the bit below the sign, the pass is marked. On the operand stream it halves every word read during the next pass, using an arithmetic right shift, when the pass before it was marked.

A transform begins with a start pulse that also loads the number of passes. Each pass ends with the result word that carries the last marker. The block counts the passes whose operands were halved. That count is the block exponent: the true output equals the integer output times two raised to the exponent. One cycle after the last result of the final pass, a done pulse is raised. The final pass's growth decision is not applied to any operand. It is reported on its own flag so that the consumer can rescale if it needs to.

Complex words are treated as a pair. Both parts take the same shift, and growth in either part marks the pass.

Top module: `bfp_scaler`

## Requirements
- R1: After reset, `exp_o` is 0, `done_o` is 0, `tail_grow_o` is 0 and `op_valid_o` is 0.
- R2: In the first pass after a start pulse, operands come out unchanged one cycle after they are accepted. This holds even if a shift was pending when the start pulse arrived.
- R3: A result word is flagged when, in either its real or its imaginary part, bit DATA_W-2 differs from the sign bit DATA_W-1. Words presented while `res_valid_i` is low are not looked at.
- R4: If any valid result of a non-final pass is flagged, every operand of the next pass leaves the block one cycle later, arithmetically shifted right by one bit. The sign bit is copied into the top, and the real and imaginary parts are shifted alike.
- R5: If no valid result of a pass is flagged, operands of the next pass leave unshifted. The flag is cleared for each pass, so growth seen two passes back has no effect.
- R6: `exp_o` returns to 0 on a start pulse. It rises by one for each non-final pass that was flagged, and it never rises by more than one per cycle.
- R7: `done_o` pulses high for exactly one cycle, one cycle after the last-marked result of the final pass is accepted. `tail_grow_o` then shows whether that final pass was flagged. That decision adds nothing to `exp_o` and shifts no later operand.
- R8: The pass count is taken from `passes_i` at the start pulse. A value of 0 acts as a single pass.
- R9: Result words that arrive outside a transform (after `done_o`, before the next start) change neither `done_o`, `exp_o` nor `tail_grow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-transform pulse |
| passes_i | input | EXP_W | Number of passes in the transform, sampled with start |
| op_valid_i | input | 1 | Operand word valid |
| op_re_i | input | DATA_W | Operand real part |
| op_im_i | input | DATA_W | Operand imaginary part |
| op_valid_o | output | 1 | Scaled operand valid |
| op_re_o | output | DATA_W | Scaled operand real part |
| op_im_o | output | DATA_W | Scaled operand imaginary part |
| res_valid_i | input | 1 | Result word valid |
| res_last_i | input | 1 | Marks the last result word of a pass |
| res_re_i | input | DATA_W | Result real part |
| res_im_i | input | DATA_W | Result imaginary part |
| exp_o | output | EXP_W | Shared block exponent |
| done_o | output | 1 | One-cycle pulse after the final pass |
| tail_grow_o | output | 1 | Growth seen in the final pass, not applied |

## Verification
A vector table runs two-pass transforms. The first pass writes back one result word, and the table covers the four top-two-bit combinations, once in the real part and once in the imaginary part. This separates a correct sign-versus-next-bit test from a check of the sign bit alone, or of one part alone. The operands of the second pass include negative values, odd values and -1. These show whether the shift is arithmetic and whether it drops the low bit correctly.

Directed runs cover the remaining cases:
- a three-pass transform whose middle pass is clean, which shows the per-pass clearing of the flag;
- a restart while a shift is pending;
- invalid words that carry growth bits;
- a zero pass count;
- stray results after done;
- a four-pass run in which every pass is flagged, which builds up the exponent.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  // Scaling mode applied by the operand stage during one pass
  typedef enum logic [0:0] {
    SCALE_PASS  = 1'b0,
    SCALE_HALVE = 1'b1
  } scale_e;

endpackage

// File: rtl/bfp_growth_acc.sv
module bfp_growth_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] re_i,
  input  logic [DATA_W-1:0] im_i,
  output logic              word_grow,
  output logic              pass_grow
);

  // Growth: the bit below the sign disagrees with the sign
  function automatic logic grew(input logic [DATA_W-1:0] w);
    return w[DATA_W-1] ^ w[DATA_W-2];
  endfunction

  logic seen_q;

  assign word_grow = grew(re_i) | grew(im_i);
  assign pass_grow = seen_q | (en & word_grow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (clr) begin
      seen_q <= 1'b0;
    end else if (en && word_grow) begin
      seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/bfp_exp_ctrl.sv
module bfp_exp_ctrl
  import bfp_pkg::*;
#(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [EXP_W-1:0] passes_i,
  input  logic             res_fire,
  input  logic             res_last,
  input  logic             pass_grow,
  output logic             busy,
  output logic             pass_end,
  output scale_e           mode,
  output logic [EXP_W-1:0] exp_o,
  output logic             done_o,
  output logic             tail_grow_o
);

  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  function automatic logic [EXP_W-1:0] sat_inc(input logic [EXP_W-1:0] e);
    return (e == EXP_MAX) ? e : e + 1'b1;
  endfunction

  logic [EXP_W-1:0] pass_idx_q;
  logic [EXP_W-1:0] npass_q;
  logic             final_pass;

  assign final_pass = ({1'b0, pass_idx_q} + 1'b1) >= {1'b0, npass_q};
  assign pass_end   = res_fire & res_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      mode        <= SCALE_PASS;
      exp_o       <= '0;
      done_o      <= 1'b0;
      tail_grow_o <= 1'b0;
      pass_idx_q  <= '0;
      npass_q     <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy        <= 1'b1;
        mode        <= SCALE_PASS;
        exp_o       <= '0;
        tail_grow_o <= 1'b0;
        pass_idx_q  <= '0;
        npass_q     <= passes_i;
      end else if (pass_end) begin
        if (final_pass) begin
          busy        <= 1'b0;
          done_o      <= 1'b1;
          tail_grow_o <= pass_grow;
          mode        <= SCALE_PASS;
        end else begin
          pass_idx_q <= pass_idx_q + 1'b1;
          mode       <= pass_grow ? SCALE_HALVE : SCALE_PASS;
          if (pass_grow) exp_o <= sat_inc(exp_o);
        end
      end
    end
  end

endmodule

// File: rtl/bfp_operand_shift.sv
module bfp_operand_shift
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scale_e            mode,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] re_i,
  input  logic [DATA_W-1:0] im_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] re_o,
  output logic [DATA_W-1:0] im_o
);

  function automatic logic [DATA_W-1:0] asr1(input logic [DATA_W-1:0] w);
    return {w[DATA_W-1], w[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] scale(input scale_e m,
                                              input logic [DATA_W-1:0] w);
    return (m == SCALE_HALVE) ? asr1(w) : w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        re_o <= scale(mode, re_i);
        im_o <= scale(mode, im_i);
      end
    end
  end

endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [EXP_W-1:0]  passes_i,
  input  logic              op_valid_i,
  input  logic [DATA_W-1:0] op_re_i,
  input  logic [DATA_W-1:0] op_im_i,
  output logic              op_valid_o,
  output logic [DATA_W-1:0] op_re_o,
  output logic [DATA_W-1:0] op_im_o,
  input  logic              res_valid_i,
  input  logic              res_last_i,
  input  logic [DATA_W-1:0] res_re_i,
  input  logic [DATA_W-1:0] res_im_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic              done_o,
  output logic              tail_grow_o
);

  // Named internal events, visible to the bound checker
  logic   busy;
  logic   res_fire;
  logic   pass_end;
  logic   word_grow;
  logic   pass_grow;
  logic   acc_clr;
  logic   shift_pend;
  scale_e mode;

  assign res_fire   = busy & res_valid_i & ~start_i;
  assign acc_clr    = start_i | pass_end;
  assign shift_pend = (mode == SCALE_HALVE);

  bfp_growth_acc #(.DATA_W(DATA_W)) u_grow (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (acc_clr),
    .en        (res_fire),
    .re_i      (res_re_i),
    .im_i      (res_im_i),
    .word_grow (word_grow),
    .pass_grow (pass_grow)
  );

  bfp_exp_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .passes_i    (passes_i),
    .res_fire    (res_fire),
    .res_last    (res_last_i),
    .pass_grow   (pass_grow),
    .busy        (busy),
    .pass_end    (pass_end),
    .mode        (mode),
    .exp_o       (exp_o),
    .done_o      (done_o),
    .tail_grow_o (tail_grow_o)
  );

  bfp_operand_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .valid_i (op_valid_i),
    .re_i    (op_re_i),
    .im_i    (op_im_i),
    .valid_o (op_valid_o),
    .re_o    (op_re_o),
    .im_o    (op_im_o)
  );

endmodule

// File: rtl/bfp_scaler_chk.sv
module bfp_scaler_chk #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              op_valid_i,
  input logic              op_valid_o,
  input logic [DATA_W-1:0] op_re_o,
  input logic [DATA_W-1:0] op_im_o,
  input logic              res_valid_i,
  input logic              res_last_i,
  input logic [EXP_W-1:0]  exp_o,
  input logic              done_o,
  input logic              busy,
  input logic              shift_pend
);

  // R2: a start pulse leaves no shift pending for the first pass
  assert_first_pass_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !shift_pend);

  // R4: a halved operand always carries a duplicated sign bit
  assert_halved_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && $past(shift_pend)) |->
      (op_re_o[DATA_W-1] == op_re_o[DATA_W-2]) &&
      (op_im_o[DATA_W-1] == op_im_o[DATA_W-2]));

  // R4: operand valid is a one-cycle delayed copy of its input
  assert_operand_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> $past(op_valid_i));

  // R6: without a start the exponent holds or climbs by exactly one
  assert_exp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (exp_o == $past(exp_o)) ||
                 (exp_o == EXP_W'($past(exp_o) + 1'b1)));

  // R7: done follows an accepted last-marked result and lasts one cycle
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(res_valid_i && res_last_i));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  // R9: no transform running and no start means no done
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> !done_o);

endmodule

bind bfp_scaler bfp_scaler_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_valid_i  (op_valid_i),
  .op_valid_o  (op_valid_o),
  .op_re_o     (op_re_o),
  .op_im_o     (op_im_o),
  .res_valid_i (res_valid_i),
  .res_last_i  (res_last_i),
  .exp_o       (exp_o),
  .done_o      (done_o),
  .busy        (busy),
  .shift_pend  (shift_pend)
);

// File: tb/sim_bfp_scaler.sv
`timescale 1ns/1ps
module sim_bfp_scaler;

  localparam int DW = 16;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [EW-1:0] passes_i = '0;
  logic          op_valid_i = 1'b0;
  logic [DW-1:0] op_re_i = '0, op_im_i = '0;
  logic          op_valid_o;
  logic [DW-1:0] op_re_o, op_im_o;
  logic          res_valid_i = 1'b0, res_last_i = 1'b0;
  logic [DW-1:0] res_re_i = '0, res_im_i = '0;
  logic [EW-1:0] exp_o;
  logic          done_o, tail_grow_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  bfp_scaler #(.DATA_W(DW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .passes_i(passes_i),
    .op_valid_i(op_valid_i), .op_re_i(op_re_i), .op_im_i(op_im_i),
    .op_valid_o(op_valid_o), .op_re_o(op_re_o), .op_im_o(op_im_o),
    .res_valid_i(res_valid_i), .res_last_i(res_last_i),
    .res_re_i(res_re_i), .res_im_i(res_im_i),
    .exp_o(exp_o), .done_o(done_o), .tail_grow_o(tail_grow_o)
  );

  // {result re, result im, operand in, operand expected out, growth flag}
  localparam logic [64:0] VEC [8] = '{
    {16'h1000, 16'h0000, 16'h1234, 16'h1234, 1'b0},
    {16'h4000, 16'h0000, 16'h1234, 16'h091A, 1'b1},
    {16'hC000, 16'h0000, 16'h8002, 16'h8002, 1'b0},
    {16'h8000, 16'h0000, 16'h8002, 16'hC001, 1'b1},
    {16'h0000, 16'h7FFF, 16'hFFFF, 16'hFFFF, 1'b1},
    {16'h3FFF, 16'hC000, 16'h0001, 16'h0001, 1'b0},
    {16'h0000, 16'hBFFF, 16'h0003, 16'h0001, 1'b1},
    {16'hFFFF, 16'hFFFF, 16'h7FFE, 16'h7FFE, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [EW-1:0] n);
    start_i = 1'b1; passes_i = n; tick(); start_i = 1'b0;
  endtask

  task automatic res_word(input logic [DW-1:0] re, input logic [DW-1:0] im, input logic last);
    res_valid_i = 1'b1; res_last_i = last; res_re_i = re; res_im_i = im;
    tick();
    res_valid_i = 1'b0; res_last_i = 1'b0;
  endtask

  task automatic op_word(input logic [DW-1:0] re, input logic [DW-1:0] im);
    op_valid_i = 1'b1; op_re_i = re; op_im_i = im;
    tick();
    op_valid_i = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 exp", 32'(exp_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 tail", 32'(tail_grow_o), 0);
    chk("R1 op_valid", 32'(op_valid_o), 0);

    // Table: two-pass transforms exercising growth detection and shift (R3 R4 R5 R6)
    for (int i = 0; i < 8; i++) begin
      do_start(2);
      res_word(VEC[i][64:49], VEC[i][48:33], 1'b1);
      chk("R7 no done mid", 32'(done_o), 0);
      op_word(VEC[i][32:17], VEC[i][32:17]);
      chk("R3_R4_R5 re", 32'(op_re_o), 32'(VEC[i][16:1]));
      chk("R3_R4_R5 im", 32'(op_im_o), 32'(VEC[i][16:1]));
      res_word(16'h0, 16'h0, 1'b1);
      chk("R7 done", 32'(done_o), 1);
      chk("R6 exp", 32'(exp_o), 32'(VEC[i][0]));
    end

    // Three passes: shift, then clean pass, then tail growth
    do_start(3);
    chk("R6 exp at start", 32'(exp_o), 0);
    op_word(16'h4000, 16'h8000);
    chk("R2 first re", 32'(op_re_o), 32'h4000);
    chk("R2 first im", 32'(op_im_o), 32'h8000);
    res_word(16'h4000, 16'h0, 1'b0);
    res_word(16'h0, 16'h0, 1'b1);
    chk("R7 not final", 32'(done_o), 0);
    op_word(16'h4000, 16'h8000);
    chk("R4 re", 32'(op_re_o), 32'h2000);
    chk("R4 im sign", 32'(op_im_o), 32'hC000);
    chk("R6 exp one", 32'(exp_o), 1);
    res_word(16'h0, 16'h0, 1'b1);
    op_word(16'h4000, 16'h8000);
    chk("R5 clean re", 32'(op_re_o), 32'h4000);
    chk("R5 clean im", 32'(op_im_o), 32'h8000);
    res_word(16'h4000, 16'h0, 1'b1);
    chk("R7 done", 32'(done_o), 1);
    chk("R7 tail", 32'(tail_grow_o), 1);
    chk("R7 exp kept", 32'(exp_o), 1);
    tick();
    chk("R7 pulse width", 32'(done_o), 0);
    op_word(16'h4000, 16'h8000);
    chk("R7 tail not applied", 32'(op_re_o), 32'h4000);

    // R9 stray result after done
    res_word(16'h4000, 16'h4000, 1'b1);
    chk("R9 done", 32'(done_o), 0);
    chk("R9 exp", 32'(exp_o), 1);
    chk("R9 tail", 32'(tail_grow_o), 1);

    // R2 restart while a shift is pending
    do_start(2);
    res_word(16'h4000, 16'h0, 1'b1);
    do_start(2);
    chk("R6 restart exp", 32'(exp_o), 0);
    op_word(16'h4000, 16'h8000);
    chk("R2 restart re", 32'(op_re_o), 32'h4000);

    // R3 invalid words carrying growth are ignored
    res_re_i = 16'h4000; res_im_i = 16'h8000; res_last_i = 1'b0;
    tick();
    res_word(16'h0, 16'h0, 1'b1);
    op_word(16'h4000, 16'h8000);
    chk("R3 invalid ignored", 32'(op_re_o), 32'h4000);
    res_word(16'h0, 16'h0, 1'b1);
    chk("R3 done", 32'(done_o), 1);
    chk("R3 exp", 32'(exp_o), 0);
    chk("R3 tail", 32'(tail_grow_o), 0);

    // R8 zero pass count acts as one pass
    do_start(0);
    res_word(16'h0, 16'h4000, 1'b1);
    chk("R8 done", 32'(done_o), 1);
    chk("R8 tail", 32'(tail_grow_o), 1);
    chk("R8 exp", 32'(exp_o), 0);

    // R6 exponent builds over several flagged passes
    do_start(4);
    for (int p = 0; p < 3; p++) res_word(16'h8000, 16'h0, 1'b1);
    chk("R6 exp three", 32'(exp_o), 3);
    res_word(16'h0, 16'h0, 1'b1);
    chk("R6 done", 32'(done_o), 1);
    chk("R6 final exp", 32'(exp_o), 3);
    chk("R6 tail", 32'(tail_grow_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule